// File: doc/BRIEF.md
# Fractional-Period Tick Generator

This block emits a one-cycle tick at a rate whose average period, measured in prescaled clocks, need not be a whole number. A counter clears when it reaches a compare value. The compare value for each period is chosen as either a short value C or a long value C+1. Over a frame of M periods, exactly K periods take the long value. The average period is therefore C + 1 + K/M prescaled clocks. For example, 10 Hz can be produced from a 1 MHz clock divided by 1024 with C = 96, K = 21 and M = 32. Every frame of 32 periods then lasts exactly 3125 prescaled clocks.

An accumulator spreads the long periods evenly across the frame rather than grouping them together. A separate strobe marks the start of each frame. Software configures the block while `run` is low, then raises `run`. Changing the settings while the block is running is not supported.

Top module: `fracTickGen`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, `tick` and `frameStart` are 0.
- R2: `prescaleSel` picks the prescaler divisor D as follows: 1 gives D=1, 2 gives D=8, 3 gives D=64, 4 gives D=256 and 5 gives D=1024. A period that uses compare value X lasts (X+1)·D clocks.
- R3: Each period uses compare value `baseCmp` (short) or `baseCmp`+1 (long). Each frame of `frameLen` (M) periods contains exactly `longCount` (K) long periods, where 0 ≤ K ≤ M ≤ 256. A frame therefore lasts (M·(C+1)+K)·D clocks.
- R4: An accumulator starts at 0 when `run` rises. For each period it adds K, and that period is long when the sum reaches M or more, in which case M is subtracted. As a result, the first period of a frame is short whenever K < M. When K/M ≤ 1/2 no two long periods are adjacent, and when K/M ≥ 1/2 no two short periods are adjacent.
- R5: `frameStart` is high for one cycle, together with the tick that ends every M-th period counted from the rise of `run`.
- R6: While `run` is low, counting stops and no tick is produced. After `run` rises with K < M and D = 1, the first tick appears on the (C+1)-th rising clock edge on which `run` is high.
- R7: Values 0, 6 and 7 of `prescaleSel` halt the prescaler, and no tick is produced.
- R8: The compare value is loaded only when a period ends or while the block is idle, so every period is exactly short or exactly long.
- R9: The degenerate settings behave as R3 predicts: K = 0 makes every period short, K = M makes every period long, and C = 0 with D = 1 gives periods of 1 or 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Counting is enabled while this is high; it restarts from the start of a frame when it rises |
| prescaleSel | input | 3 | Prescaler divisor select |
| baseCmp | input | 8 | Short compare value C |
| longCount | input | 9 | Number of long periods per frame, K |
| frameLen | input | 9 | Periods per frame, M (1..256) |
| tick | output | 1 | One-cycle pulse at the end of each period |
| frameStart | output | 1 | One-cycle pulse at the end of each frame, coinciding with its tick |

## Verification
A period ends when the counter is at its compare value on a prescaled step. The tick is registered, so it appears one edge after that step, and period lengths measured from tick to tick carry no offset. Outputs are sampled at the falling clock edge. Intervals are taken as differences between the cycle numbers of consecutive ticks. Frames are measured starting from a `frameStart` pulse, so each period's position in the frame is known. First-tick latency is counted in rising edges from the falling edge on which `run` is raised; the tick is due after the (C+1)-th edge.

// File: rtl/fracTickPkg.sv
package fracTickPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic step;     // one prescaled clock
    logic restart;  // idle: clear and preload first period
  } ctrlStrobes_t;
endpackage

// File: rtl/fracTickCtrl.sv
module fracTickCtrl
  import fracTickPkg::*;
#(
  parameter int PS_W    = 10,
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic [2:0]         prescaleSel,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic               periodEnd,
  output ctrlStrobes_t       strobes,
  output logic               tick,
  output logic               frameStart
);
  logic [PS_W-1:0]    psLimit;
  logic               psValid;
  logic [PS_W-1:0]    psCnt;
  logic [FRAME_W-1:0] frameIdx;
  logic               psHit;
  logic               lastInFrame;

  always_comb begin
    psValid = 1'b1;
    psLimit = '0;
    case (prescaleSel)
      3'd1:    psLimit = PS_W'(0);
      3'd2:    psLimit = PS_W'(7);
      3'd3:    psLimit = PS_W'(63);
      3'd4:    psLimit = PS_W'(255);
      3'd5:    psLimit = PS_W'(1023);
      default: psValid = 1'b0;
    endcase
  end

  assign psHit           = (psCnt == psLimit);
  assign strobes.step    = run && psValid && psHit;
  assign strobes.restart = !run;
  assign lastInFrame     = (frameIdx == frameLen - FRAME_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (!run || !psValid || psHit) begin
      psCnt <= '0;
    end else begin
      psCnt <= psCnt + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameIdx   <= '0;
      tick       <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      tick       <= periodEnd;
      frameStart <= periodEnd && lastInFrame;
      if (!run) begin
        frameIdx <= '0;
      end else if (periodEnd) begin
        frameIdx <= lastInFrame ? '0 : frameIdx + FRAME_W'(1);
      end
    end
  end
endmodule

// File: rtl/fracTickDp.sv
module fracTickDp
  import fracTickPkg::*;
#(
  parameter int CMP_W   = 8,
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [CMP_W-1:0]   baseCmp,
  input  logic [FRAME_W-1:0] longCount,
  input  logic [FRAME_W-1:0] frameLen,
  output logic               periodEnd,
  output logic [CMP_W:0]     curCmp
);
  localparam int ACC_W = FRAME_W + 1;

  logic [CMP_W:0]     count;
  logic [FRAME_W-1:0] acc;
  logic [ACC_W-1:0]   accIn;
  logic [ACC_W-1:0]   accSum;
  logic               takeLong;
  logic [FRAME_W-1:0] nextAcc;
  logic [CMP_W:0]     nextCmp;

  assign accIn     = strobes.restart ? '0 : ACC_W'(acc);
  assign accSum    = accIn + ACC_W'(longCount);
  assign takeLong  = (accSum >= ACC_W'(frameLen));
  assign nextAcc   = FRAME_W'(takeLong ? accSum - ACC_W'(frameLen) : accSum);
  assign nextCmp   = {1'b0, baseCmp} + (CMP_W+1)'(takeLong);
  assign periodEnd = strobes.step && (count == curCmp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      acc    <= '0;
      curCmp <= '0;
    end else if (strobes.restart || periodEnd) begin
      count  <= '0;
      acc    <= nextAcc;
      curCmp <= nextCmp;
    end else if (strobes.step) begin
      count  <= count + (CMP_W+1)'(1);
    end
  end
endmodule

// File: rtl/fracTickGen.sv
module fracTickGen
  import fracTickPkg::*;
#(
  parameter int CMP_W   = 8,
  parameter int FRAME_W = 9,
  parameter int PS_W    = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic [2:0]         prescaleSel,
  input  logic [CMP_W-1:0]   baseCmp,
  input  logic [FRAME_W-1:0] longCount,
  input  logic [FRAME_W-1:0] frameLen,
  output logic               tick,
  output logic               frameStart
);
  ctrlStrobes_t   strobes;
  logic           dpPeriodEnd;
  logic [CMP_W:0] dpCurCmp;

  fracTickCtrl #(.PS_W(PS_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .prescaleSel(prescaleSel),
    .frameLen(frameLen), .periodEnd(dpPeriodEnd), .strobes(strobes),
    .tick(tick), .frameStart(frameStart)
  );

  fracTickDp #(.CMP_W(CMP_W), .FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .baseCmp(baseCmp),
    .longCount(longCount), .frameLen(frameLen),
    .periodEnd(dpPeriodEnd), .curCmp(dpCurCmp)
  );
endmodule

// File: rtl/fracTickChecker.sv
module fracTickChecker #(
  parameter int CMP_W = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           run,
  input logic [2:0]     prescaleSel,
  input logic [CMP_W-1:0] baseCmp,
  input logic           tick,
  input logic           frameStart,
  input logic           periodEnd,
  input logic [CMP_W:0] curCmp
);
  assert_idle_no_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !tick);

  assert_halt_sel_no_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(prescaleSel inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}) |=> !tick);

  assert_frame_with_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> tick);

  assert_cmp_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    run && !periodEnd |=> $stable(curCmp));

  assert_cmp_two_values_R3: assert property (@(posedge clk) disable iff (!rstN)
    run && $past(run) |-> (curCmp == {1'b0, baseCmp} || curCmp == {1'b0, baseCmp} + 1'b1));

  always @(negedge clk) begin
    if (!rstN) assert_reset_quiet_R1: assert (!tick && !frameStart);
  end
endmodule

bind fracTickGen fracTickChecker #(.CMP_W(CMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .run(run), .prescaleSel(prescaleSel),
  .baseCmp(baseCmp), .tick(tick), .frameStart(frameStart),
  .periodEnd(dpPeriodEnd), .curCmp(dpCurCmp)
);

// File: tb/test_fracTickGen.sv
`timescale 1ns/1ps
module test_fracTickGen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       run = 1'b0;
  logic [2:0] prescaleSel = 3'd1;
  logic [7:0] baseCmp = 8'd0;
  logic [8:0] longCount = 9'd0;
  logic [8:0] frameLen = 9'd1;
  logic       tick;
  logic       frameStart;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  fracTickGen i_fracTickGen (
    .clk(clk), .rstN(rstN), .run(run), .prescaleSel(prescaleSel),
    .baseCmp(baseCmp), .longCount(longCount), .frameLen(frameLen),
    .tick(tick), .frameStart(frameStart)
  );

  // C, K, M, sel, divisor, expected frame length in clocks
  localparam int NV = 9;
  localparam int V_C[NV]   = '{96, 9, 9, 4, 0, 2,   1, 0,   0};
  localparam int V_K[NV]   = '{21, 0, 4, 1, 1, 255, 1, 0,   1};
  localparam int V_M[NV]   = '{32, 4, 4, 3, 2, 256, 2, 1,   1};
  localparam int V_SEL[NV] = '{1,  1, 1, 2, 1, 1,   3, 4,   5};
  localparam int V_DIV[NV] = '{1,  1, 1, 8, 1, 1,   64, 256, 1024};
  localparam int V_TOT[NV] = '{3125, 40, 44, 128, 3, 1023, 320, 256, 2048};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic quietWindow(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!tick && !frameStart, "R1 during reset", {tick, frameStart}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!tick && !frameStart, "R1 after reset", {tick, frameStart}, 0);

    // Table walk: R2 R3 R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      int lastT, d, tot, longs, odd, fsBad, shortRuns, firstLen;
      bit prevShort;
      int sLen, lLen;
      run = 1'b0;
      baseCmp = 8'(V_C[v]); longCount = 9'(V_K[v]);
      frameLen = 9'(V_M[v]); prescaleSel = 3'(V_SEL[v]);
      repeat (3) @(negedge clk);
      run = 1'b1;
      do waitTick(); while (!frameStart);
      sLen = (V_C[v] + 1) * V_DIV[v];
      lLen = (V_C[v] + 2) * V_DIV[v];
      lastT = cyc; tot = 0; longs = 0; odd = 0; fsBad = 0;
      shortRuns = 0; prevShort = 1'b0; firstLen = 0;
      for (int p = 0; p < V_M[v]; p++) begin
        waitTick();
        d = cyc - lastT;
        lastT = cyc;
        tot += d;
        if (p == 0) firstLen = d;
        if (d == lLen) begin
          longs++; prevShort = 1'b0;
        end else if (d == sLen) begin
          if (prevShort) shortRuns++;
          prevShort = 1'b1;
        end else odd++;
        if (frameStart != (p == V_M[v] - 1)) fsBad++;
      end
      check(tot == V_TOT[v], "R2 R3 frame length", tot, V_TOT[v]);
      check(longs == V_K[v], "R3 R9 long count", longs, V_K[v]);
      check(odd == 0, "R8 period is short or long", odd, 0);
      check(fsBad == 0, "R5 frameStart placement", fsBad, 0);
      if (v == 0) begin
        check(firstLen == sLen, "R4 first period short", firstLen, sLen);
        check(shortRuns == 0, "R4 no adjacent shorts", shortRuns, 0);
      end
    end

    // R6: idle produces nothing, and first-tick latency
    run = 1'b0; baseCmp = 8'd5; longCount = 9'd0; frameLen = 9'd1; prescaleSel = 3'd1;
    quietWindow(50, "R6 idle");
    run = 1'b1;
    begin
      int early = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (tick) early++;
      end
      check(early == 0, "R6 no early tick", early, 0);
      @(negedge clk);
      check(tick == 1'b1, "R6 first tick at edge C+1", tick, 1);
    end

    // R7: halted selects
    run = 1'b0; @(negedge clk);
    prescaleSel = 3'd0; run = 1'b1;
    quietWindow(40, "R7 select 0");
    prescaleSel = 3'd6;
    quietWindow(40, "R7 select 6");
    prescaleSel = 3'd7;
    quietWindow(40, "R7 select 7");
    run = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule